// File: doc/BRIEF.md
# Repeating Alarm Controller with Chime

This block watches a set of calendar-clock digits (half-second flag, seconds, minutes, hours, weekday, day of month, month) and raises an alarm when a chosen subset of them equals a stored alarm setting. A 4-bit mask code picks the subset. The codes run from an alarm on every half-second tick up to an alarm once a year. The digits are sampled only on a clock update tick supplied by the time-keeping logic next to this block.

Each alarm event produces a one-cycle interrupt pulse and flips a level output. That level output therefore runs at half the alarm rate. An 8-bit repeat counter sets how many further alarms follow the first. When the counter is spent, the block clears its own enable. In chime mode the counter wraps instead and the alarm never stops. A simple write port loads the alarm digits and a configuration word.

Top module: `alarm_ctrl`

## Requirements
- R1: Mask codes select the digits that must match. Code 0 matches on every tick. Code 1 compares the half-second flag. Code 2 compares half plus seconds. Code 3 adds minutes. Code 4 adds hours. Code 5 compares half, seconds, minutes, hours and weekday. Code 6 compares half, seconds, minutes, hours and day of month. Code 7 compares the same digits as code 6 plus the month.
- R2: An event occurs only when three conditions hold together: `tick` is high, the alarm is enabled, and the masked digits match. For codes 1 to 7, the match must also have been absent at the previous tick. For code 0, every enabled tick is an event. `alarm_irq` is high for exactly the one cycle after the clock edge that samples the event tick.
- R3: A match that persists across consecutive ticks gives only one event.
- R4: At an event with a nonzero repeat count, the count decreases by one and the alarm stays enabled.
- R5: At an event with a repeat count of zero and chime off, that event is the last one and `alarm_en` clears. A count of zero therefore gives exactly one alarm.
- R6: At an event with a repeat count of zero and chime on, the count becomes 255 and the alarm stays enabled.
- R7: Mask codes 8 to 15 never produce an event.
- R8: `alarm_pulse` resets to 0 and inverts on every event.
- R9: Register map, written while `wr_en` is high:
  - Address 0 holds half at bit 0 and seconds at bits 6:1.
  - Address 1 holds minutes at bits 5:0 and hours at bits 12:8.
  - Address 2 holds weekday at bits 2:0, day at bits 8:4 and month at bits 15:12.
  - Address 3 holds the repeat count at bits 7:0, the mask at bits 11:8, chime at bit 12 and enable at bit 15.
  
  Writes to addresses 0 to 2 are ignored while the alarm is enabled. Writes to address 3 are always accepted.
- R10: Enabling the alarm while the digits already match does not fire. The first event waits for a tick on which the match newly appears.
- R11: After reset, `alarm_irq`, `alarm_pulse` and `alarm_en` are 0 and `repeat_left` is 0.
- R12: While the alarm is disabled, no event occurs, whatever the digits do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock-digit update strobe |
| cur_half | input | 1 | Current half-second flag |
| cur_sec | input | 6 | Current seconds |
| cur_min | input | 6 | Current minutes |
| cur_hour | input | 5 | Current hours |
| cur_wday | input | 3 | Current weekday |
| cur_day | input | 5 | Current day of month |
| cur_month | input | 4 | Current month |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| alarm_irq | output | 1 | One-cycle alarm interrupt |
| alarm_pulse | output | 1 | Level that inverts on each alarm |
| alarm_en | output | 1 | Alarm enable state |
| repeat_left | output | 8 | Remaining repeat count |

## Verification
On every cycle, the assertions check the following:
- an interrupt follows an enabled tick;
- reserved mask codes stay silent;
- the pulse output inverts exactly with the interrupt;
- the counter decrements, wraps or disables as the chime and count dictate;
- alarm digits hold still under writes while enabled.

Only the bench scenarios can show the match rules themselves. These are the rising-match rule across persistent matches, the digit subsets of each mask code, and the absence of a shot on enabling over an existing match. The bench also shows that a sequence of shots ends after exactly count plus one events.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  parameter int SEC_W  = 6;
  parameter int MIN_W  = 6;
  parameter int HOUR_W = 5;
  parameter int WDAY_W = 3;
  parameter int DAY_W  = 5;
  parameter int MON_W  = 4;
  parameter int RPT_W  = 8;
  parameter int MASK_W = 4;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 2;
  localparam int NDIG  = 7;

  typedef struct packed {
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  day;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
    logic              half;
  } digits_t;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC  = 2'd0,
    A_HRMN = 2'd1,
    A_DATE = 2'd2,
    A_CFG  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic            valid;
    logic            every;
    logic [NDIG-1:0] sel;
  } mask_dec_t;

  // sel bit order: 0 half, 1 sec, 2 min, 3 hour, 4 wday, 5 day, 6 month
  function automatic mask_dec_t decode_mask(input logic [MASK_W-1:0] code);
    mask_dec_t d;
    d.valid = 1'b1;
    d.every = 1'b0;
    d.sel   = '0;
    case (code)
      4'd0: d.every = 1'b1;
      4'd1: d.sel = 7'b0000001;
      4'd2: d.sel = 7'b0000011;
      4'd3: d.sel = 7'b0000111;
      4'd4: d.sel = 7'b0001111;
      4'd5: d.sel = 7'b0011111;
      4'd6: d.sel = 7'b0101111;
      4'd7: d.sel = 7'b1101111;
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alm_on,
  output digits_t           alm_val,
  output logic [MASK_W-1:0] mask,
  output logic              chime,
  output logic              cfg_wr,
  output logic              cfg_en,
  output logic [RPT_W-1:0]  cfg_rpt
);
  localparam int SEC_LSB  = 1;
  localparam int HOUR_LSB = 8;
  localparam int DAY_LSB  = 4;
  localparam int MON_LSB  = 12;
  localparam int MASK_LSB = 8;
  localparam int CHM_BIT  = 12;
  localparam int EN_BIT   = 15;

  digits_t           val_q, val_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              chime_q, chime_d;
  logic              val_wr;

  assign val_wr = wr_en && (wr_addr != A_CFG) && !alm_on;
  assign cfg_wr = wr_en && (wr_addr == A_CFG);

  always_comb begin
    val_d   = val_q;
    mask_d  = mask_q;
    chime_d = chime_q;
    if (val_wr) begin
      case (wr_addr)
        A_SEC: begin
          val_d.half = wr_data[0];
          val_d.sec  = wr_data[SEC_LSB +: SEC_W];
        end
        A_HRMN: begin
          val_d.min  = wr_data[0 +: MIN_W];
          val_d.hour = wr_data[HOUR_LSB +: HOUR_W];
        end
        A_DATE: begin
          val_d.wday = wr_data[0 +: WDAY_W];
          val_d.day  = wr_data[DAY_LSB +: DAY_W];
          val_d.mon  = wr_data[MON_LSB +: MON_W];
        end
        default: ;
      endcase
    end
    if (cfg_wr) begin
      mask_d  = wr_data[MASK_LSB +: MASK_W];
      chime_d = wr_data[CHM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      mask_q  <= '0;
      chime_q <= 1'b0;
    end else begin
      val_q   <= val_d;
      mask_q  <= mask_d;
      chime_q <= chime_d;
    end
  end

  assign alm_val = val_q;
  assign mask    = mask_q;
  assign chime   = chime_q;
  assign cfg_en  = wr_data[EN_BIT];
  assign cfg_rpt = wr_data[0 +: RPT_W];

  // R9: the alarm digits do not move under a write made while enabled
  p_value_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != A_CFG) && alm_on) |=> $stable(val_q));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  digits_t           cur,
  input  digits_t           alm,
  input  logic [MASK_W-1:0] mask,
  output logic              fire
);
  mask_dec_t       dec;
  logic [NDIG-1:0] eq;
  logic [NDIG-1:0] need;
  logic            hit_now;
  logic            prev_q, prev_d;

  assign dec   = decode_mask(mask);
  assign eq[0] = (cur.half == alm.half);
  assign eq[1] = (cur.sec  == alm.sec);
  assign eq[2] = (cur.min  == alm.min);
  assign eq[3] = (cur.hour == alm.hour);
  assign eq[4] = (cur.wday == alm.wday);
  assign eq[5] = (cur.day  == alm.day);
  assign eq[6] = (cur.mon  == alm.mon);

  for (genvar g = 0; g < NDIG; g++) begin : g_need
    assign need[g] = eq[g] || !dec.sel[g];
  end

  assign hit_now = dec.valid && (dec.every || (&need));
  assign fire    = tick && hit_now && (dec.every || !prev_q);

  always_comb begin
    prev_d = prev_q;
    if (tick) prev_d = hit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/alarm_seq.sv
module alarm_seq
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             chime,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic [RPT_W-1:0] cfg_rpt,
  output logic             en,
  output logic [RPT_W-1:0] rpt,
  output logic             irq,
  output logic             pulse
);
  localparam logic [RPT_W-1:0] RPT_MAX = {RPT_W{1'b1}};

  logic             en_q, en_d;
  logic [RPT_W-1:0] rpt_q, rpt_d;
  logic             irq_q, irq_d;
  logic             pls_q, pls_d;
  logic             event_ok;

  assign event_ok = fire && en_q && !cfg_wr;

  always_comb begin
    en_d  = en_q;
    rpt_d = rpt_q;
    irq_d = 1'b0;
    pls_d = pls_q;
    if (cfg_wr) begin
      en_d  = cfg_en;
      rpt_d = cfg_rpt;
    end else if (event_ok) begin
      irq_d = 1'b1;
      pls_d = !pls_q;
      if (rpt_q != '0)  rpt_d = rpt_q - 1'b1;
      else if (chime)   rpt_d = RPT_MAX;
      else              en_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rpt_q <= '0;
      irq_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      rpt_q <= rpt_d;
      irq_q <= irq_d;
      pls_q <= pls_d;
    end
  end

  assign en    = en_q;
  assign rpt   = rpt_q;
  assign irq   = irq_q;
  assign pulse = pls_q;

  // R4: a shot with count left decrements and keeps the alarm on
  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en_q && !cfg_wr && rpt_q != '0) |=> (rpt_q == $past(rpt_q) - 1'b1) && en_q);
  // R5: last shot without chime turns the alarm off
  p_last_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en_q && !cfg_wr && rpt_q == '0 && !chime) |=> !en_q);
  // R6: chime wraps the count instead of disabling
  p_chime_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en_q && !cfg_wr && rpt_q == '0 && chime) |=> en_q && rpt_q == RPT_MAX);
  // R8: pulse level inverts exactly when an interrupt is issued
  p_pulse_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (pls_q != $past(pls_q)));
  p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> $stable(pls_q));
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cur_half,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [MON_W-1:0]  cur_month,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              alarm_irq,
  output logic              alarm_pulse,
  output logic              alarm_en,
  output logic [RPT_W-1:0]  repeat_left
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  digits_t           cur;
  digits_t           alm_val;
  logic [MASK_W-1:0] mask;
  logic              chime;
  logic              cfg_wr;
  logic              cfg_en;
  logic [RPT_W-1:0]  cfg_rpt;
  logic              fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign cur = '{mon: cur_month, day: cur_day, wday: cur_wday, hour: cur_hour,
                 min: cur_min, sec: cur_sec, half: cur_half};

  alarm_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alm_on(alarm_en), .alm_val(alm_val), .mask(mask),
    .chime(chime), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_rpt(cfg_rpt)
  );

  alarm_match u_match (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .cur(cur), .alm(alm_val),
    .mask(mask), .fire(fire)
  );

  alarm_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .fire(fire), .chime(chime),
    .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_rpt(cfg_rpt), .en(alarm_en),
    .rpt(repeat_left), .irq(alarm_irq), .pulse(alarm_pulse)
  );

  // R2: an interrupt only follows an update tick
  p_irq_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    alarm_irq |-> $past(tick));
  // R12: no interrupt unless the alarm was enabled
  p_irq_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    alarm_irq |-> $past(alarm_en));
  // R7: reserved mask codes stay silent
  p_reserved_silent_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    alarm_irq |-> ($past(mask) < 4'd8));
endmodule

// File: tb/alarm_ctrl_bench.sv
`timescale 1ns/1ps
module alarm_ctrl_bench;
  import alarm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  digits_t     d = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        alarm_irq, alarm_pulse, alarm_en;
  logic [7:0]  repeat_left;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alarm_ctrl u_alarm_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_half(d.half), .cur_sec(d.sec),
    .cur_min(d.min), .cur_hour(d.hour), .cur_wday(d.wday), .cur_day(d.day),
    .cur_month(d.mon), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alarm_irq(alarm_irq), .alarm_pulse(alarm_pulse), .alarm_en(alarm_en),
    .repeat_left(repeat_left)
  );

  // reference model state
  digits_t m_val = '0;
  bit [3:0] m_mask = 0;
  bit m_chime = 0, m_en = 0, m_prev = 0, m_pulse = 0, m_irq = 0;
  bit [7:0] m_rpt = 0;

  function automatic bit model_hit(digits_t c, digits_t a, bit [3:0] code);
    bit h, s, mi, hr, wd, dy, mo;
    h = c.half == a.half; s = c.sec == a.sec; mi = c.min == a.min;
    hr = c.hour == a.hour; wd = c.wday == a.wday; dy = c.day == a.day;
    mo = c.mon == a.mon;
    case (code)
      0: return 1;
      1: return h;
      2: return h & s;
      3: return h & s & mi;
      4: return h & s & mi & hr;
      5: return h & s & mi & hr & wd;
      6: return h & s & mi & hr & dy;
      7: return h & s & mi & hr & dy & mo;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "alarm_irq", alarm_irq, m_irq);
    check(tag, "alarm_pulse", alarm_pulse, m_pulse);
    check(tag, "alarm_en", alarm_en, m_en);
    check(tag, "repeat_left", repeat_left, m_rpt);
  endtask

  task automatic step(string tag, bit tk, digits_t dv);
    bit hit, fire;
    @(negedge clk);
    tick = tk; d = dv;
    hit  = model_hit(dv, m_val, m_mask);
    fire = tk && m_en && hit && (m_mask == 0 || !m_prev);
    if (tk) m_prev = hit;
    m_irq = fire;
    if (fire) begin
      m_pulse = !m_pulse;
      if (m_rpt != 0) m_rpt--;
      else if (m_chime) m_rpt = 8'hFF;
      else m_en = 0;
    end
    @(posedge clk); #1;
    check_all(tag);
    tick = 0;
  endtask

  task automatic wr(string tag, bit [1:0] a, bit [15:0] v);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = v; tick = 0;
    m_irq = 0;
    if (a == 3) begin
      m_rpt = v[7:0]; m_mask = v[11:8]; m_chime = v[12]; m_en = v[15];
    end else if (!m_en) begin
      case (a)
        0: begin m_val.half = v[0]; m_val.sec = v[6:1]; end
        1: begin m_val.min = v[5:0]; m_val.hour = v[12:8]; end
        default: begin m_val.wday = v[2:0]; m_val.day = v[8:4]; m_val.mon = v[15:12]; end
      endcase
    end
    @(posedge clk); #1;
    wr_en = 0;
    check_all(tag);
  endtask

  function automatic bit [15:0] cfg(bit en, bit chm, bit [3:0] mk, bit [7:0] r);
    return {en, 2'b00, chm, mk, r};
  endfunction

  task automatic load_val(string tag, digits_t v);
    wr(tag, 0, {9'd0, v.sec, v.half});
    wr(tag, 1, {3'd0, v.hour, 2'd0, v.min});
    wr(tag, 2, {v.mon, 3'd0, v.day, 1'b0, v.wday});
  endtask

  function automatic digits_t near(digits_t a);
    digits_t r;
    r = a;
    if ($urandom_range(3) == 0) r.half = 1'($urandom);
    if ($urandom_range(3) == 0) r.sec  = 6'($urandom);
    if ($urandom_range(5) == 0) r.min  = 6'($urandom);
    if ($urandom_range(5) == 0) r.hour = 5'($urandom);
    if ($urandom_range(5) == 0) r.wday = 3'($urandom);
    if ($urandom_range(5) == 0) r.day  = 5'($urandom);
    if ($urandom_range(5) == 0) r.mon  = 4'($urandom);
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    digits_t a, x;
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check_all("R11");

    a = '{mon: 4, day: 7, wday: 2, hour: 3, min: 5, sec: 10, half: 0};
    load_val("R9", a);
    x = a; x.sec = 0;
    step("R12", 1, a);                       // disabled: no shot
    step("R2", 1, x);
    wr("R4", 3, cfg(1, 0, 2, 2));
    step("R2", 1, a);                        // first shot
    step("R3", 1, a);                        // persists: silent
    step("R2", 1, x);
    step("R2", 0, a);                        // no tick: silent
    step("R4", 1, a);                        // second shot
    step("R2", 1, x);
    step("R5", 1, a);                        // final shot, disables
    step("R2", 1, x);
    step("R12", 1, a);

    // R10: enable over an existing match
    step("R10", 1, a);
    wr("R10", 3, cfg(1, 0, 2, 0));
    step("R10", 1, a);
    step("R10", 1, x);
    step("R5", 1, a);

    // R9: value writes ignored while enabled
    wr("R9", 3, cfg(1, 0, 2, 1));
    step("R9", 1, x);
    wr("R9", 0, {9'd0, 6'd20, 1'b0});
    x.sec = 20;
    step("R9", 1, x);
    step("R9", 1, a);
    x.sec = 0;

    // R7: reserved codes
    for (int k = 8; k < 16; k++) begin
      wr("R7", 3, cfg(1, 0, 4'(k), 3));
      step("R7", 1, x);
      step("R7", 1, a);
    end

    // R6: chime wrap with half-second code, R8 pulse
    wr("R6", 3, cfg(1, 1, 1, 0));
    for (int k = 0; k < 8; k++) begin
      x = a; x.half = 1'(k);
      step("R6", 1, x);
    end
    // code 0 fires every tick
    wr("R1", 3, cfg(1, 0, 0, 3));
    for (int k = 0; k < 6; k++) step("R1", 1, a);

    // R1: each code ignores digits outside its set
    for (int k = 1; k < 8; k++) begin
      wr("R1", 3, cfg(1, 0, 4'(k), 8'hFF));
      x = a; x.mon = 9; x.wday = 6;
      step("R1", 1, x);
      step("R1", 1, a);
    end

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(99);
      if (r < 3) begin
        bit [3:0] mk;
        mk = ($urandom_range(9) == 0) ? 4'($urandom_range(15, 8)) : 4'($urandom_range(7));
        wr("R9", 3, cfg(1'($urandom_range(3) != 0), 1'($urandom), mk, 8'($urandom_range(3))));
      end else if (r < 5) begin
        a = near(a);
        load_val("R9", a);
      end else begin
        step("R4", 1'($urandom_range(9) != 0), near(m_val));
      end
    end
    finish_run();
  end
endmodule